// File: doc/BRIEF.md
# Modem Status Scanner Controller

This block watches four modem input signals (carrier detect, clear to send, ring indicator and secondary receive) on a parameterised set of serial lines. A pointer walks the lines one per clock. On each line it compares the synchronised inputs with a stored copy. When any of them differ, the walk halts on that line. The block then latches the line number and one flag for each signal that changed, sets a done indication and, if enabled, raises an interrupt. Each line also owns four output controls (line enable, data terminal ready, request to send, secondary transmit), and the host sets these through a per-line status register.

The host sees two 16-bit registers, chosen by a one-bit address: a control/status word at address 0 and the status of the selected line at address 1. Before the host selects a line, it turns scanning off and waits for the busy bit to drop. It then writes the line number and reads or writes that line's status. To acknowledge a report and carry on, the host writes scan enable again, with interrupt enable if wanted. A maintenance mode loops each line's own outputs back into its inputs, so software can exercise the scanner without a modem.

Top module: `modem_scan_ctrl`

## Requirements
- R1: After reset the control word (address 0) reads 0x0000, the interrupt output is low and every line output is low.
- R2: While scan enable (control bit 5) is set and done (bit 7) is clear, a line whose synchronised inputs differ from its stored copy stops the scan. Done is set, bits 3:0 hold that line, and exactly the changed signals are flagged: bit 15 ring, bit 14 carrier, bit 13 clear to send, bit 12 secondary receive. The pointer stays on that line while done remains set.
- R3: The interrupt output is high exactly while done and interrupt enable (control bit 6) are both set; with interrupt enable clear, a report sets done without an interrupt.
- R4: Busy (control bit 4) reads 1 while scan enable is set and for one further cycle after a write clears it, then reads 0.
- R5: Any control write clears done and the four flags. A write with scan enable set leaves the pointer where it stopped and resumes there, and a change that has already been reported is not reported again.
- R6: A control write with scan enable clear loads the line number from bits 3:0. If step (bit 8) is also set, the pointer advances by one instead, wrapping from the last line to line 0.
- R7: A write to address 1 sets the selected line's outputs from bit 0 line enable, bit 1 data terminal ready, bit 2 request to send and bit 3 secondary transmit. A read of address 1 returns those four bits, plus bit 4 secondary receive, bit 5 clear to send, bit 6 carrier and bit 7 ring as the line currently sees them.
- R8: A write to address 1 while busy reads 1 is ignored and changes no line output.
- R9: A control write with bit 10 set clears all four outputs on every line.
- R10: A control write with bit 11 set moves the pointer to line 0, clears done and the flags, and loads every stored copy from the current inputs, so that changes made before it are never reported.
- R11: While maintenance (control bit 9) is set, each line sees carrier from its own data terminal ready, clear to send from its request to send, secondary receive from its secondary transmit, and ring as 0.
- R12: If a control write falls in the same cycle as a detection, the write takes effect and the detection is dropped for that cycle. The change stays pending and is reported on a later scan cycle.
- R13: Modem inputs pass through SYNC_STAGES clocked stages (default 2). A change driven at a port appears in a line status read after exactly that many rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 1 | 0 selects the control word, 1 the selected line's status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the register at bus_addr |
| car_in | input | LINES | Carrier detect per line, asynchronous |
| cts_in | input | LINES | Clear to send per line, asynchronous |
| ring_in | input | LINES | Ring indicator per line, asynchronous |
| srx_in | input | LINES | Secondary receive per line, asynchronous |
| dtr_out | output | LINES | Data terminal ready per line |
| rts_out | output | LINES | Request to send per line |
| stx_out | output | LINES | Secondary transmit per line |
| len_out | output | LINES | Line enable per line |
| irq | output | 1 | Interrupt request |

## Verification
A host write to the control word can land in the same clock edge as the scanner finding a changed line, and the two compete for the done bit, the flags and the pointer. The bench sets up this collision deterministically. It parks the pointer on a line with scanning off and changes that line's carrier. It then issues two control writes with scan enable on consecutive edges, so that the second write lands on the first edge where the scan is live. It expects done to read 0 right after the second write and the carrier report for that line one edge later. Scan reports are checked by a monitor against a queue of expected control words, so a lost, repeated or extra report shows up as a miscompare.

// File: rtl/msc_pkg.sv
package msc_pkg;

   // Control word bit positions (decoded by host software)
   localparam int CTL_RING    = 15;
   localparam int CTL_CAR     = 14;
   localparam int CTL_CTS     = 13;
   localparam int CTL_SRX     = 12;
   localparam int CTL_CLRSCAN = 11;
   localparam int CTL_CLRMUX  = 10;
   localparam int CTL_MAINT   = 9;
   localparam int CTL_STEP    = 8;
   localparam int CTL_DONE    = 7;
   localparam int CTL_IE      = 6;
   localparam int CTL_SE      = 5;
   localparam int CTL_BUSY    = 4;
   localparam int CTL_LINE_W  = 4;

   // Line status word bit positions
   localparam int LS_LE   = 0;
   localparam int LS_DTR  = 1;
   localparam int LS_RTS  = 2;
   localparam int LS_STX  = 3;
   localparam int LS_SRX  = 4;
   localparam int LS_CTS  = 5;
   localparam int LS_CAR  = 6;
   localparam int LS_RING = 7;

   // Observed modem signals; packed order matches control bits 15:12
   // and line status bits 7:4.
   typedef struct packed {
      logic ring;
      logic car;
      logic cts;
      logic srx;
   } mdm_sig_t;

   // Driven modem signals; packed order matches line status bits 3:0.
   typedef struct packed {
      logic stx;
      logic rts;
      logic dtr;
      logic le;
   } mdm_drv_t;

endpackage

// File: rtl/msc_sync.sv
module msc_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("msc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("msc_sync: W must be positive");
   end

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
      end else begin
         chain_q[0] <= d;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/msc_line_ctrl.sv
module msc_line_ctrl
   import msc_pkg::*;
#(
   parameter int LINES = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             busy,
   input  logic             clr_all,
   input  logic [IDX_W-1:0] sel,
   input  mdm_drv_t         wr_val,
   output logic [LINES-1:0] le_o,
   output logic [LINES-1:0] dtr_o,
   output logic [LINES-1:0] rts_o,
   output logic [LINES-1:0] stx_o,
   output mdm_drv_t         sel_val
);

   mdm_drv_t drv_all [LINES];
   logic     wr_ok;

   assign wr_ok = wr_req && !busy;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      mdm_drv_t drv_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            drv_q <= '0;
         end else if (clr_all) begin
            drv_q <= '0;
         end else if (wr_ok && (sel == IDX_W'(g))) begin
            drv_q <= wr_val;
         end
      end

      assign drv_all[g] = drv_q;
      assign le_o[g]    = drv_q.le;
      assign dtr_o[g]   = drv_q.dtr;
      assign rts_o[g]   = drv_q.rts;
      assign stx_o[g]   = drv_q.stx;
   end

   assign sel_val = drv_all[sel];

   // R8: a status write during busy leaves every output untouched
   assert_busy_write_ignored_R8 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (wr_req && busy && !clr_all) |=>
         ($stable(le_o) && $stable(dtr_o) && $stable(rts_o) && $stable(stx_o)));

   // R9: clearing all lines empties every output
   assert_clear_all_R9 : assert property (
      @(posedge clk) disable iff (!rst_n)
      clr_all |=> (le_o == '0 && dtr_o == '0 && rts_o == '0 && stx_o == '0));

endmodule

// File: rtl/msc_scanner.sv
module msc_scanner
   import msc_pkg::*;
#(
   parameter int LINES = 16,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scan_en,
   input  logic             ctl_wr,
   input  logic             wr_se,
   input  logic             wr_step,
   input  logic [IDX_W-1:0] wr_line,
   input  logic             clr_scan,
   input  mdm_sig_t         seen [LINES],
   output logic [IDX_W-1:0] ptr,
   output logic             done,
   output mdm_sig_t         flags
);

   localparam logic [IDX_W-1:0] PTR_ONE = IDX_W'(1);

   mdm_sig_t         copy_q [LINES];
   logic [IDX_W-1:0] ptr_q;
   logic             done_q;
   mdm_sig_t         flags_q;

   mdm_sig_t cur;
   mdm_sig_t diff;
   logic     hit;
   logic     scan_live;

   always_comb begin
      cur       = seen[ptr_q];
      diff      = cur ^ copy_q[ptr_q];
      hit       = |diff;
      scan_live = scan_en && !done_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q   <= '0;
         done_q  <= 1'b0;
         flags_q <= '0;
         for (int i = 0; i < LINES; i++) copy_q[i] <= '0;
      end else if (clr_scan) begin
         ptr_q   <= '0;
         done_q  <= 1'b0;
         flags_q <= '0;
         for (int i = 0; i < LINES; i++) copy_q[i] <= seen[i];
      end else if (ctl_wr) begin
         // host access wins over a same-cycle detection
         done_q  <= 1'b0;
         flags_q <= '0;
         if (!wr_se) begin
            ptr_q <= wr_step ? (ptr_q + PTR_ONE) : wr_line;
         end
      end else if (scan_live) begin
         if (hit) begin
            done_q         <= 1'b1;
            flags_q        <= diff;
            copy_q[ptr_q]  <= cur;
         end else begin
            ptr_q <= ptr_q + PTR_ONE;
         end
      end
   end

   assign ptr   = ptr_q;
   assign done  = done_q;
   assign flags = flags_q;

   // R2: a report carries at least one flag
   assert_report_has_flag_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (flags_q != '0));

   // R2: the pointer stays parked on the reported line until the host acts
   assert_park_on_report_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (done_q && !ctl_wr && !clr_scan) |=> ($stable(ptr_q) && done_q));

   // R12: a control write in the same cycle suppresses the detection
   assert_write_beats_scan_R12 : assert property (
      @(posedge clk) disable iff (!rst_n)
      ctl_wr |=> !done_q);

   // R6: step advances the pointer by exactly one
   assert_step_advance_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (ctl_wr && !clr_scan && !wr_se && wr_step) |=>
         (ptr_q == $past(ptr_q) + PTR_ONE));

endmodule

// File: rtl/modem_scan_ctrl.sv
module modem_scan_ctrl
   import msc_pkg::*;
#(
   parameter int LINES        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit HAS_LOOPBACK = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [15:0]      bus_wdata,
   output logic [15:0]      bus_rdata,
   input  logic [LINES-1:0] car_in,
   input  logic [LINES-1:0] cts_in,
   input  logic [LINES-1:0] ring_in,
   input  logic [LINES-1:0] srx_in,
   output logic [LINES-1:0] dtr_out,
   output logic [LINES-1:0] rts_out,
   output logic [LINES-1:0] stx_out,
   output logic [LINES-1:0] len_out,
   output logic             irq
);

   localparam int IDX_W  = $clog2(LINES);
   localparam int SYNC_W = 4 * LINES;

   if (LINES < 2 || LINES > (1 << CTL_LINE_W)) begin : g_bad_lines
      $error("modem_scan_ctrl: LINES must lie between 2 and 16");
   end
   if ((1 << IDX_W) != LINES) begin : g_bad_pow2
      $error("modem_scan_ctrl: LINES must be a power of two");
   end

   // ---------------- register access decode ----------------
   logic ctl_wr, lsr_wr, clr_mux, clr_scan;
   assign ctl_wr   = bus_wr && !bus_addr;
   assign lsr_wr   = bus_wr &&  bus_addr;
   assign clr_mux  = ctl_wr && bus_wdata[CTL_CLRMUX];
   assign clr_scan = ctl_wr && bus_wdata[CTL_CLRSCAN];

   logic ie_q, se_q, maint_q, se_tail_q, busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q      <= 1'b0;
         se_q      <= 1'b0;
         maint_q   <= 1'b0;
         se_tail_q <= 1'b0;
      end else begin
         se_tail_q <= se_q;
         if (ctl_wr) begin
            ie_q    <= bus_wdata[CTL_IE];
            se_q    <= bus_wdata[CTL_SE];
            maint_q <= bus_wdata[CTL_MAINT];
         end
      end
   end

   assign busy = se_q || se_tail_q;

   // ---------------- input synchronisation ----------------
   logic [SYNC_W-1:0] sync_q;
   logic [LINES-1:0]  ring_s, car_s, cts_s, srx_s;

   msc_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ring_in, car_in, cts_in, srx_in}),
      .q     (sync_q)
   );

   assign {ring_s, car_s, cts_s, srx_s} = sync_q;

   // ---------------- per-line output controls ----------------
   logic [IDX_W-1:0] ptr;
   mdm_drv_t         sel_drv;
   mdm_drv_t         lsr_wval;

   assign lsr_wval = mdm_drv_t'(bus_wdata[LS_STX:LS_LE]);

   msc_line_ctrl #(.LINES(LINES), .IDX_W(IDX_W)) u_lines (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (lsr_wr),
      .busy    (busy),
      .clr_all (clr_mux),
      .sel     (ptr),
      .wr_val  (lsr_wval),
      .le_o    (len_out),
      .dtr_o   (dtr_out),
      .rts_o   (rts_out),
      .stx_o   (stx_out),
      .sel_val (sel_drv)
   );

   // ---------------- observed signals, with optional loopback ----------------
   logic     maint_eff;
   mdm_sig_t seen [LINES];

   if (HAS_LOOPBACK) begin : g_loop
      assign maint_eff = maint_q;
      for (genvar g = 0; g < LINES; g++) begin : g_seen
         assign seen[g] = maint_eff ?
            mdm_sig_t'({1'b0, dtr_out[g], rts_out[g], stx_out[g]}) :
            mdm_sig_t'({ring_s[g], car_s[g], cts_s[g], srx_s[g]});
      end
   end else begin : g_noloop
      assign maint_eff = 1'b0;
      for (genvar g = 0; g < LINES; g++) begin : g_seen
         assign seen[g] = mdm_sig_t'({ring_s[g], car_s[g], cts_s[g], srx_s[g]});
      end
   end

   // ---------------- scanner ----------------
   logic     done;
   mdm_sig_t flags;

   msc_scanner #(.LINES(LINES), .IDX_W(IDX_W)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .scan_en  (se_q),
      .ctl_wr   (ctl_wr),
      .wr_se    (bus_wdata[CTL_SE]),
      .wr_step  (bus_wdata[CTL_STEP]),
      .wr_line  (bus_wdata[IDX_W-1:0]),
      .clr_scan (clr_scan),
      .seen     (seen),
      .ptr      (ptr),
      .done     (done),
      .flags    (flags)
   );

   // ---------------- read-back ----------------
   mdm_sig_t    sel_seen;
   logic [15:0] ctl_word, lsr_word;

   assign sel_seen = seen[ptr];

   always_comb begin
      ctl_word                          = '0;
      ctl_word[CTL_RING:CTL_SRX]        = flags;
      ctl_word[CTL_MAINT]               = maint_eff;
      ctl_word[CTL_DONE]                = done;
      ctl_word[CTL_IE]                  = ie_q;
      ctl_word[CTL_SE]                  = se_q;
      ctl_word[CTL_BUSY]                = busy;
      ctl_word[CTL_LINE_W-1:0]          = CTL_LINE_W'(ptr);

      lsr_word                          = '0;
      lsr_word[LS_RING:LS_SRX]          = sel_seen;
      lsr_word[LS_STX:LS_LE]            = sel_drv;
   end

   assign bus_rdata = bus_addr ? lsr_word : ctl_word;
   assign irq       = done && ie_q;

   logic unused_wdata;
   assign unused_wdata = ^{bus_wdata[15:12], bus_wdata[CTL_DONE], bus_wdata[CTL_BUSY],
                           bus_wdata[CTL_LINE_W-1:0]};

   // R4: busy survives the cycle after scan enable is cleared
   assert_busy_tail_R4 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $fell(se_q) |-> busy);

   // R3: the interrupt falls once a control write acknowledges the report
   assert_irq_drops_on_ack_R3 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (irq && ctl_wr) |=> !irq);

endmodule

// File: tb/modem_scan_ctrl_bench.sv
module modem_scan_ctrl_bench;

   localparam int CLK_PERIOD = 10;
   localparam int N          = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic          bus_addr = 1'b0;
   logic [15:0]   bus_wdata = '0;
   logic [15:0]   bus_rdata;
   logic [N-1:0]  car_in = '0;
   logic [N-1:0]  cts_in = '0;
   logic [N-1:0]  ring_in = '0;
   logic [N-1:0]  srx_in = '0;
   logic [N-1:0]  dtr_out, rts_out, stx_out, len_out;
   logic          irq;

   int            n_chk = 0;
   int            n_fail = 0;
   int            evt_cnt = 0;
   int            exp_evts = 0;
   logic [15:0]   exp_q [$];

   modem_scan_ctrl #(.LINES(N)) u_modem_scan_ctrl (
      .clk (clk), .rst_n (rst_n),
      .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
      .car_in (car_in), .cts_in (cts_in), .ring_in (ring_in), .srx_in (srx_in),
      .dtr_out (dtr_out), .rts_out (rts_out), .stx_out (stx_out), .len_out (len_out),
      .irq (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // caller sits just after a falling edge; one rising edge performs the write
   task automatic wr(input logic a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_addr  = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [15:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
      bus_addr = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic expect_report(input logic [15:0] word);
      exp_q.push_back(word);
      exp_evts++;
   endtask

   task automatic wait_reports(input string tag);
      int k = 0;
      while (evt_cnt < exp_evts && k < 300) begin
         @(negedge clk);
         k++;
      end
      chk(tag, 16'(evt_cnt), 16'(exp_evts));
   endtask

   // monitor: pops one expected control word per rising interrupt
   initial begin
      logic irq_prev = 1'b0;
      forever begin
         @(negedge clk);
         #2;
         if (rst_n) begin
            if (irq && !irq_prev) begin
               if (exp_q.size() == 0) begin
                  chk("R3 unexpected interrupt", bus_rdata, 16'h0000);
               end else begin
                  chk("R2 scan report word", bus_rdata, exp_q.pop_front());
               end
               evt_cnt++;
            end
            irq_prev = irq;
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(1'b0, v);
      chk("R1 control after reset", v, 16'h0000);
      chk("R1 irq after reset", 16'(irq), 16'h0000);
      chk("R1 outputs after reset", 16'(dtr_out | rts_out | stx_out | len_out), 16'h0000);

      // R6 pointer load, step, wrap
      wr(1'b0, 16'h0005);
      rd(1'b0, v); chk("R6 load line 5", v, 16'h0005);
      wr(1'b0, 16'h0100);
      rd(1'b0, v); chk("R6 step to 6", v, 16'h0006);
      wr(1'b0, 16'h000F);
      wr(1'b0, 16'h0100);
      rd(1'b0, v); chk("R6 step wraps to 0", v, 16'h0000);

      // R7 line outputs on line 2
      wr(1'b0, 16'h0002);
      wr(1'b1, 16'h000B);
      chk("R7 dtr_out", dtr_out, 16'h0004);
      chk("R7 len_out", len_out, 16'h0004);
      chk("R7 stx_out", stx_out, 16'h0004);
      chk("R7 rts_out", rts_out, 16'h0000);
      rd(1'b1, v); chk("R7 status readback", v, 16'h000B);

      // R13 synchroniser depth: clear to send on line 2
      @(negedge clk);
      cts_in[2] = 1'b1;
      @(negedge clk);
      rd(1'b1, v); chk("R13 one edge, old value", v, 16'h000B);
      @(negedge clk);
      rd(1'b1, v); chk("R13 two edges, new value (R7 bit5)", v, 16'h002B);

      // R9 clear all outputs
      wr(1'b0, 16'h0400);
      chk("R9 outputs cleared", 16'(dtr_out | rts_out | stx_out | len_out), 16'h0000);
      wr(1'b0, 16'h0002);
      rd(1'b1, v); chk("R9 line 2 status after clear", v, 16'h0020);

      // R10 clear scan discards earlier changes
      wr(1'b0, 16'h0800);
      wr(1'b0, 16'h0060);
      idle(40);
      chk("R10 no report after clear scan", 16'(irq), 16'h0000);
      rd(1'b0, v); chk("R10 done clear", v & 16'h0080, 16'h0000);

      // R2 / R3 / R5 scoreboard reports
      expect_report(16'h40FB);
      car_in[11] = 1'b1;
      wait_reports("R2 carrier rise line 11");
      chk("R3 irq high with report", 16'(irq), 16'h0001);
      wr(1'b0, 16'h0060);
      idle(40);
      chk("R5 no repeat report", 16'(evt_cnt), 16'(exp_evts));

      expect_report(16'hA0F4);
      ring_in[4] = 1'b1;
      cts_in[4]  = 1'b1;
      wait_reports("R2 ring and cts line 4");
      wr(1'b0, 16'h0060);

      expect_report(16'h10F0);
      srx_in[0] = 1'b1;
      wait_reports("R2 secondary receive line 0");
      wr(1'b0, 16'h0060);

      expect_report(16'h40FB);
      car_in[11] = 1'b0;
      wait_reports("R5 carrier fall line 11 after resume");
      wr(1'b0, 16'h0060);
      idle(40);
      chk("R5 nothing further pending", 16'(evt_cnt), 16'(exp_evts));

      // R3 with interrupt enable clear
      wr(1'b0, 16'h0020);
      cts_in[6] = 1'b1;
      idle(40);
      chk("R3 no irq without enable", 16'(irq), 16'h0000);
      rd(1'b0, v); chk("R3 done set silently, line 6", v, 16'h20B6);
      wr(1'b0, 16'h0060);

      // R8 status write ignored while busy
      wr(1'b1, 16'h000F);
      chk("R8 outputs unchanged while busy", 16'(dtr_out | rts_out | stx_out | len_out), 16'h0000);
      wr(1'b0, 16'h0000);

      // R4 busy tail
      wr(1'b0, 16'h0020);
      rd(1'b0, v); chk("R4 busy with scan enable", v & 16'h0030, 16'h0030);
      wr(1'b0, 16'h0000);
      rd(1'b0, v); chk("R4 busy one cycle after stop", v & 16'h0030, 16'h0010);
      @(negedge clk);
      rd(1'b0, v); chk("R4 busy released", v & 16'h0030, 16'h0000);

      // R12 host write and detection in the same cycle
      wr(1'b0, 16'h0005);
      car_in[5] = 1'b1;
      idle(3);
      wr(1'b0, 16'h0020);
      wr(1'b0, 16'h0020);
      rd(1'b0, v); chk("R12 write wins, no report yet", v, 16'h0035);
      @(negedge clk);
      rd(1'b0, v); chk("R12 report follows next cycle", v, 16'h40B5);
      wr(1'b0, 16'h0000);

      // R11 maintenance loopback on line 3
      wr(1'b0, 16'h0A00);
      wr(1'b0, 16'h0203);
      wr(1'b1, 16'h0002);
      rd(1'b1, v); chk("R11 carrier looped from dtr", v, 16'h0042);
      expect_report(16'h42F3);
      wr(1'b0, 16'h0260);
      wait_reports("R11 loopback report line 3");
      wr(1'b0, 16'h0000);

      idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule